// File: doc/BRIEF.md
# SPI Flash Command Front End

This block is the serial slave side of a NOR-style SPI memory. It takes the raw chip-select, serial-clock, serial-in and hold pins and brings them into the system clock domain through two-flop synchronizers. It frames each transfer between a falling and a rising chip-select edge. It collects an 8-bit opcode, MSB first, and classifies it. For commands that carry an address, it then gathers three address bytes and keeps the low 19 bits. Once the command header is complete, it hands the opcode and address to a back end with a single-cycle pulse.

After the header, the block works in one of two directions. For write-class commands it delivers each further received byte with a strobe. For read-class commands it asks the back end for bytes and shifts them out on SO on falling SCK edges.

A qualified hold pauses shifting and floats SO without losing the frame. An unknown opcode makes the block deaf to SI until the next selection. The back end's busy flag is folded into a standby-ready indication. SCK must run at no more than a quarter of the system clock. Both SPI mode 0 (idle low) and mode 3 (idle high) work.

Top module: `spi_cmd_frontend`

## Requirements
- R1: A frame opens only on a high-to-low transition of `cs_n_pin` and closes on its low-to-high transition; a new selection always restarts opcode collection.
- R2: SI is taken on rising SCK edges, most significant bit first, with SCK idling either low or high.
- R3: The first 8 bits of a frame are the opcode; if chip select rises before the 8th bit, no command and no strobe is produced.
- R4: Supported opcodes are 01h, 02h, 03h, 04h, 05h, 06h, 20h, 36h, 39h, 52h, 60h, 9Fh, C7h and D8h. Any other opcode produces no `cmd_valid`, no `rx_strobe` and no `tx_req` for the rest of that frame.
- R5: Opcodes 02h, 03h, 20h, 36h, 39h, 52h and D8h are followed by 24 address bits, and `cmd_addr` carries the low 19 of them (for example, 123456h gives 23456h). For all other opcodes `cmd_addr` is zero and `cmd_has_addr` is low. A deselect inside the address produces no command.
- R6: `cmd_valid` is a one-cycle pulse issued once per frame when the opcode and any address are complete, with `cmd_op`, `cmd_addr` and `cmd_has_addr` valid in that cycle.
- R7: After the header of a receive-class opcode (01h, 02h), every 8 further bits give one `rx_strobe` with the byte on `rx_byte`, MSB first. Other opcodes give no `rx_strobe`.
- R8: For transmit-class opcodes (03h, 05h, 9Fh), `tx_req` pulses at the end of the header and after every 8 further SCK rises. `tx_byte` is captured at the end of the cycle in which `tx_req` is high. The byte then appears on `so_out` MSB first, one bit per falling SCK edge, and `so_out` changes at no other time.
- R9: `so_oe` is low while deselected, while a hold is active, and outside the data phase of a transmit-class opcode.
- R10: A hold starts only while selected with SCK low and `hold_n_pin` low, and ends when `hold_n_pin` returns high. During a hold, SCK edges and SI are ignored and the shift position is kept, so the transfer resumes exactly where it stopped.
- R11: `standby_ready` is high only when deselected, with no frame in progress and `be_busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_pin | input | 1 | Chip select pin, active low |
| sck_pin | input | 1 | Serial clock pin |
| si_pin | input | 1 | Serial data in |
| hold_n_pin | input | 1 | Hold request, active low |
| so_out | output | 1 | Serial data out value |
| so_oe | output | 1 | Output enable for SO (low means high-impedance) |
| cmd_valid | output | 1 | Command header complete pulse |
| cmd_op | output | 8 | Decoded opcode |
| cmd_addr | output | 19 | Internal address (low 19 bits) |
| cmd_has_addr | output | 1 | Opcode carried an address |
| rx_strobe | output | 1 | Received data byte pulse |
| rx_byte | output | 8 | Received data byte |
| tx_req | output | 1 | Request for the next byte to transmit |
| tx_byte | input | 8 | Byte to transmit, captured with `tx_req` |
| be_busy | input | 1 | Back end is running a self-timed operation |
| standby_ready | output | 1 | Deselected, idle and back end not busy |

## Verification
Several properties are checked on every clock. `cmd_valid` lasts one cycle, and address-less commands report a zero address. `cmd_valid` and `rx_strobe` never coincide, and nothing is issued during an active hold. SO changes only after a detected falling SCK edge. The output enable drops after deselection, and a busy back end clears standby-ready.

Other behaviours only show up in the bench's scripted transfers. These include the exact opcode and address values, including truncation of the upper address bits. They also include the silence after short frames and unknown opcodes, and transmit bytes arriving in order. Finally, they include hold resuming at the same bit, and hold not starting while SCK is high, in both idle-clock polarities.

// File: rtl/sfe_pkg.sv
package sfe_pkg;

    typedef enum logic [2:0] {
        FS_IDLE,
        FS_OPC,
        FS_ADDR,
        FS_DATA,
        FS_SKIP
    } frame_st_e;

    typedef struct packed {
        logic known;
        logic addr;
        logic rx;
        logic tx;
    } op_class_t;

    localparam logic [7:0] OP_WR_STATUS = 8'h01;
    localparam logic [7:0] OP_PROGRAM   = 8'h02;
    localparam logic [7:0] OP_READ      = 8'h03;
    localparam logic [7:0] OP_WR_DIS    = 8'h04;
    localparam logic [7:0] OP_RD_STATUS = 8'h05;
    localparam logic [7:0] OP_WR_EN     = 8'h06;
    localparam logic [7:0] OP_ERASE_S   = 8'h20;
    localparam logic [7:0] OP_PROT      = 8'h36;
    localparam logic [7:0] OP_UNPROT    = 8'h39;
    localparam logic [7:0] OP_ERASE_M   = 8'h52;
    localparam logic [7:0] OP_CHIP_A    = 8'h60;
    localparam logic [7:0] OP_IDENT     = 8'h9F;
    localparam logic [7:0] OP_CHIP_B    = 8'hC7;
    localparam logic [7:0] OP_ERASE_L   = 8'hD8;

    function automatic op_class_t classify(input logic [7:0] op);
        op_class_t c;
        c = '0;
        unique case (op)
            OP_WR_STATUS:               c = '{known: 1'b1, addr: 1'b0, rx: 1'b1, tx: 1'b0};
            OP_PROGRAM:                 c = '{known: 1'b1, addr: 1'b1, rx: 1'b1, tx: 1'b0};
            OP_READ:                    c = '{known: 1'b1, addr: 1'b1, rx: 1'b0, tx: 1'b1};
            OP_RD_STATUS, OP_IDENT:     c = '{known: 1'b1, addr: 1'b0, rx: 1'b0, tx: 1'b1};
            OP_WR_DIS, OP_WR_EN,
            OP_CHIP_A, OP_CHIP_B:       c = '{known: 1'b1, addr: 1'b0, rx: 1'b0, tx: 1'b0};
            OP_ERASE_S, OP_ERASE_M,
            OP_ERASE_L, OP_PROT,
            OP_UNPROT:                  c = '{known: 1'b1, addr: 1'b1, rx: 1'b0, tx: 1'b0};
            default:                    c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/sfe_sync.sv
module sfe_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg_d [STAGES];
    logic [W-1:0] stg_q [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[g] <= RST_VAL;
                else        stg_q[g] <= stg_d[g];
            end
        end
    endgenerate

    assign q = stg_q[STAGES-1];

endmodule

// File: rtl/sfe_frame.sv
module sfe_frame
    import sfe_pkg::*;
#(
    parameter int ADDR_W     = 19,
    parameter int ADDR_BYTES = 3,
    parameter int BYTE_W     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              cs_fall,
    input  logic              rise_evt,
    input  logic              si_bit,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_has_addr,
    output logic              rx_strobe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_req,
    output logic              tx_phase,
    output logic              frame_idle
);

    localparam int HDR_BITS = ADDR_BYTES * BYTE_W;
    localparam int CNT_W    = $clog2(HDR_BITS);
    localparam logic [CNT_W-1:0] LAST_BYTE_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] LAST_ADDR_BIT = CNT_W'(HDR_BITS - 1);

    typedef struct packed {
        frame_st_e           st;
        logic [CNT_W-1:0]    cnt;
        logic [HDR_BITS-1:0] sh;
        op_class_t           cls;
        logic [BYTE_W-1:0]   op;
        logic [ADDR_W-1:0]   addr;
        logic                has_addr;
        logic                vld;
        logic                rxs;
        logic [BYTE_W-1:0]   rxb;
        logic                txr;
    } fr_t;

    fr_t fr_d, fr_q;
    logic [HDR_BITS-1:0] shifted;
    op_class_t           cls_new;

    always_comb begin
        shifted = {fr_q.sh[HDR_BITS-2:0], si_bit};
        cls_new = classify(shifted[BYTE_W-1:0]);
        fr_d     = fr_q;
        fr_d.vld = 1'b0;
        fr_d.rxs = 1'b0;
        fr_d.txr = 1'b0;

        if (cs_fall) begin
            fr_d.st  = FS_OPC;
            fr_d.cnt = '0;
            fr_d.sh  = '0;
        end else if (!sel) begin
            fr_d.st  = FS_IDLE;
            fr_d.cnt = '0;
        end else if (rise_evt) begin
            unique case (fr_q.st)
                FS_OPC: begin
                    fr_d.sh = shifted;
                    if (fr_q.cnt == LAST_BYTE_BIT) begin
                        fr_d.cnt = '0;
                        fr_d.cls = cls_new;
                        fr_d.op  = shifted[BYTE_W-1:0];
                        if (!cls_new.known) begin
                            fr_d.st = FS_SKIP;
                        end else if (cls_new.addr) begin
                            fr_d.st = FS_ADDR;
                        end else begin
                            fr_d.st       = FS_DATA;
                            fr_d.vld      = 1'b1;
                            fr_d.addr     = '0;
                            fr_d.has_addr = 1'b0;
                            fr_d.txr      = cls_new.tx;
                        end
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                FS_ADDR: begin
                    fr_d.sh = shifted;
                    if (fr_q.cnt == LAST_ADDR_BIT) begin
                        fr_d.cnt      = '0;
                        fr_d.st       = FS_DATA;
                        fr_d.vld      = 1'b1;
                        fr_d.addr     = shifted[ADDR_W-1:0];
                        fr_d.has_addr = 1'b1;
                        fr_d.txr      = fr_q.cls.tx;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                FS_DATA: begin
                    fr_d.sh = shifted;
                    if (fr_q.cnt == LAST_BYTE_BIT) begin
                        fr_d.cnt = '0;
                        fr_d.rxs = fr_q.cls.rx;
                        fr_d.rxb = shifted[BYTE_W-1:0];
                        fr_d.txr = fr_q.cls.tx;
                    end else begin
                        fr_d.cnt = fr_q.cnt + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fr_q    <= '0;
            fr_q.st <= FS_IDLE;
        end else begin
            fr_q <= fr_d;
        end
    end

    assign cmd_valid    = fr_q.vld;
    assign cmd_op       = fr_q.op;
    assign cmd_addr     = fr_q.addr;
    assign cmd_has_addr = fr_q.has_addr;
    assign rx_strobe    = fr_q.rxs;
    assign rx_byte      = fr_q.rxb;
    assign tx_req       = fr_q.txr;
    assign tx_phase     = (fr_q.st == FS_DATA) && fr_q.cls.tx;
    assign frame_idle   = (fr_q.st == FS_IDLE);

endmodule

// File: rtl/sfe_tx.sv
module sfe_tx #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              hold_act,
    input  logic              tx_phase,
    input  logic              tx_req,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              fall_evt,
    output logic              so_out,
    output logic              so_oe
);

    typedef struct packed {
        logic [BYTE_W-1:0] sh;
        logic              so;
        logic              oe;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d    = tx_q;
        tx_d.oe = sel && !hold_act && tx_phase;
        if (tx_req) begin
            tx_d.sh = tx_byte;
        end else if (fall_evt && tx_phase) begin
            tx_d.so = tx_q.sh[BYTE_W-1];
            tx_d.sh = {tx_q.sh[BYTE_W-2:0], 1'b0};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tx_q <= '0;
        else        tx_q <= tx_d;
    end

    assign so_out = tx_q.so;
    assign so_oe  = tx_q.oe;

endmodule

// File: rtl/spi_cmd_frontend.sv
module spi_cmd_frontend #(
    parameter int ADDR_W     = 19,
    parameter int ADDR_BYTES = 3,
    parameter int BYTE_W     = 8,
    parameter int SYNC_STG   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_pin,
    input  logic              sck_pin,
    input  logic              si_pin,
    input  logic              hold_n_pin,
    output logic              so_out,
    output logic              so_oe,
    output logic              cmd_valid,
    output logic [BYTE_W-1:0] cmd_op,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_has_addr,
    output logic              rx_strobe,
    output logic [BYTE_W-1:0] rx_byte,
    output logic              tx_req,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              be_busy,
    output logic              standby_ready
);

    localparam int          PIN_N   = 4;
    localparam logic [PIN_N-1:0] PIN_RST = 4'b1001;

    logic [PIN_N-1:0] pins_s;
    logic cs_n_s, sck_s, si_s, hold_n_s;

    sfe_sync #(.W(PIN_N), .STAGES(SYNC_STG), .RST_VAL(PIN_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({cs_n_pin, sck_pin, si_pin, hold_n_pin}),
        .q     (pins_s)
    );

    assign {cs_n_s, sck_s, si_s, hold_n_s} = pins_s;

    typedef struct packed {
        logic sck_prev;
        logic sel_prev;
        logic hold;
        logic stby;
    } top_t;

    top_t tp_d, tp_q;
    logic sel, hold_act, cs_fall, rise_evt, fall_evt;
    logic tx_phase, frame_idle;

    assign sel      = !cs_n_s;
    assign hold_act = tp_q.hold;
    assign cs_fall  = sel && !tp_q.sel_prev;
    assign rise_evt = sel && !hold_act && sck_s && !tp_q.sck_prev;
    assign fall_evt = sel && !hold_act && !sck_s && tp_q.sck_prev;

    always_comb begin
        tp_d          = tp_q;
        tp_d.sck_prev = sck_s;
        tp_d.sel_prev = sel;
        if (!sel) begin
            tp_d.hold = 1'b0;
        end else if (tp_q.hold) begin
            tp_d.hold = !hold_n_s;
        end else begin
            tp_d.hold = !hold_n_s && !sck_s;
        end
        tp_d.stby = !sel && frame_idle && !be_busy;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tp_q <= '0;
        else        tp_q <= tp_d;
    end

    assign standby_ready = tp_q.stby;

    sfe_frame #(.ADDR_W(ADDR_W), .ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .sel          (sel),
        .cs_fall      (cs_fall),
        .rise_evt     (rise_evt),
        .si_bit       (si_s),
        .cmd_valid    (cmd_valid),
        .cmd_op       (cmd_op),
        .cmd_addr     (cmd_addr),
        .cmd_has_addr (cmd_has_addr),
        .rx_strobe    (rx_strobe),
        .rx_byte      (rx_byte),
        .tx_req       (tx_req),
        .tx_phase     (tx_phase),
        .frame_idle   (frame_idle)
    );

    sfe_tx #(.BYTE_W(BYTE_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (sel),
        .hold_act (hold_act),
        .tx_phase (tx_phase),
        .tx_req   (tx_req),
        .tx_byte  (tx_byte),
        .fall_evt (fall_evt),
        .so_out   (so_out),
        .so_oe    (so_oe)
    );

endmodule

// File: rtl/sfe_props.sv
module sfe_props #(
    parameter int ADDR_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              hold_act,
    input logic              fall_evt,
    input logic              so_out,
    input logic              so_oe,
    input logic              cmd_valid,
    input logic [ADDR_W-1:0] cmd_addr,
    input logic              cmd_has_addr,
    input logic              rx_strobe,
    input logic              tx_req,
    input logic              be_busy,
    input logic              standby_ready
);

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    a_r5_noaddr_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_has_addr) |-> (cmd_addr == '0));

    a_r7_cmd_rx_apart: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cmd_valid, rx_strobe}));

    a_r10_hold_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        hold_act |-> (!cmd_valid && !rx_strobe && !tx_req));

    a_r8_so_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !fall_evt |=> $stable(so_out));

    a_r9_float_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> !so_oe);

    a_r11_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        be_busy |=> !standby_ready);

endmodule

bind spi_cmd_frontend sfe_props #(.ADDR_W(ADDR_W)) u_props (
    .clk           (clk),
    .rst_n         (rst_n),
    .sel           (sel),
    .hold_act      (hold_act),
    .fall_evt      (fall_evt),
    .so_out        (so_out),
    .so_oe         (so_oe),
    .cmd_valid     (cmd_valid),
    .cmd_addr      (cmd_addr),
    .cmd_has_addr  (cmd_has_addr),
    .rx_strobe     (rx_strobe),
    .tx_req        (tx_req),
    .be_busy       (be_busy),
    .standby_ready (standby_ready)
);

// File: tb/sim_spi_cmd_frontend.sv
module sim_spi_cmd_frontend;

    localparam int HALF = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n, cs_n, sck, si, hold_n, be_busy;
    logic so_out, so_oe, cmd_valid, cmd_has_addr, rx_strobe, tx_req, standby_ready;
    logic [7:0]  cmd_op, rx_byte, tx_byte;
    logic [18:0] cmd_addr;

    spi_cmd_frontend u0 (
        .clk(clk), .rst_n(rst_n), .cs_n_pin(cs_n), .sck_pin(sck), .si_pin(si),
        .hold_n_pin(hold_n), .so_out(so_out), .so_oe(so_oe), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_has_addr(cmd_has_addr),
        .rx_strobe(rx_strobe), .rx_byte(rx_byte), .tx_req(tx_req), .tx_byte(tx_byte),
        .be_busy(be_busy), .standby_ready(standby_ready)
    );

    int checks = 0;
    int errors = 0;
    logic [7:0]  q_op[$];
    logic [18:0] q_addr[$];
    logic        q_ha[$];
    logic [7:0]  q_rx[$];
    int          tx_cnt = 0;
    int          txreq_seen = 0;
    int          desel_run = 0;

    function automatic logic [7:0] txb(input int n);
        return 8'(8'h5A + n * 37);
    endfunction

    always_comb tx_byte = txb(tx_cnt);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // behavioural monitor and per-clock model of SO float while deselected (R9)
    always @(negedge clk) begin
        if (rst_n) begin
            if (cmd_valid) begin
                q_op.push_back(cmd_op);
                q_addr.push_back(cmd_addr);
                q_ha.push_back(cmd_has_addr);
            end
            if (rx_strobe) q_rx.push_back(rx_byte);
            if (tx_req) begin
                tx_cnt++;
                txreq_seen++;
            end
            desel_run = cs_n ? desel_run + 1 : 0;
            if (desel_run >= 4) chk("R9 so_oe while deselected", {31'd0, so_oe}, 32'd0);
        end
    end

    task automatic clear_q();
        q_op.delete(); q_addr.delete(); q_ha.delete(); q_rx.delete();
        txreq_seen = 0;
    endtask

    task automatic sel_on(input bit m3);
        @(negedge clk);
        sck  = m3;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_off(input bit m3);
        @(negedge clk);
        sck = m3;
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (8) @(negedge clk);
    endtask

    task automatic clk_bit(input logic b, output logic r);
        @(negedge clk);
        sck = 1'b0;
        si  = b;
        repeat (HALF) @(negedge clk);
        r   = so_out;
        sck = 1'b1;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) clk_bit(b[i], r[i]);
    endtask

    task automatic header(input bit m3, input logic [7:0] op, input logic [23:0] a, input bit with_a);
        logic [7:0] dmy;
        sel_on(m3);
        send_byte(op, dmy);
        if (with_a) begin
            send_byte(a[23:16], dmy);
            send_byte(a[15:8], dmy);
            send_byte(a[7:0], dmy);
        end
    endtask

    task automatic expect_cmd(input string req, input logic [7:0] op, input logic [18:0] a, input logic ha);
        chk({req, " command count"}, q_op.size(), 1);
        if (q_op.size() == 1) begin
            chk({req, " opcode"}, {24'd0, q_op[0]}, {24'd0, op});
            chk({req, " address"}, {13'd0, q_addr[0]}, {13'd0, a});
            chk({req, " has_addr"}, {31'd0, q_ha[0]}, {31'd0, ha});
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r0, r1, dmy;
        logic       b;
        int         base;
        rst_n = 1'b0; cs_n = 1'b1; sck = 1'b0; si = 1'b0; hold_n = 1'b1; be_busy = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (6) @(negedge clk);

        // reset state
        chk("R9 reset so_oe", {31'd0, so_oe}, 0);
        chk("R11 reset standby_ready", {31'd0, standby_ready}, 1);
        chk("R6 no command after reset", q_op.size(), 0);

        // R5 R2 mode 0 small-block erase, upper address bits dropped
        clear_q();
        header(1'b0, 8'h20, 24'h123456, 1'b1);
        sel_off(1'b0);
        expect_cmd("R5 erase 20h mode0", 8'h20, 19'h23456, 1'b1);

        // R2 mode 3 large-block erase, all-ones address
        clear_q();
        header(1'b1, 8'hD8, 24'hFFFFFF, 1'b1);
        sel_off(1'b1);
        expect_cmd("R2 erase D8h mode3", 8'hD8, 19'h7FFFF, 1'b1);

        // R5 mid-size erase
        clear_q();
        header(1'b0, 8'h52, 24'h07ABCD, 1'b1);
        sel_off(1'b0);
        expect_cmd("R5 erase 52h", 8'h52, 19'h7ABCD, 1'b1);

        // R6 address-less command
        clear_q();
        header(1'b0, 8'h06, 24'h0, 1'b0);
        sel_off(1'b0);
        expect_cmd("R6 write enable 06h", 8'h06, 19'h0, 1'b0);

        // R3 deselect after 5 opcode bits, then R1 a fresh frame works
        clear_q();
        sel_on(1'b0);
        for (int i = 0; i < 5; i++) clk_bit(1'b1, b);
        sel_off(1'b0);
        chk("R3 short opcode gives no command", q_op.size(), 0);
        header(1'b1, 8'h04, 24'h0, 1'b0);
        sel_off(1'b1);
        expect_cmd("R1 new frame after abort", 8'h04, 19'h0, 1'b0);

        // R4 unknown opcode followed by bytes that look like valid commands
        clear_q();
        header(1'b0, 8'hFF, 24'h0, 1'b0);
        send_byte(8'h06, dmy);
        send_byte(8'h02, dmy);
        send_byte(8'h03, dmy);
        send_byte(8'h55, dmy);
        sel_off(1'b0);
        chk("R4 unknown opcode no command", q_op.size(), 0);
        chk("R4 unknown opcode no rx strobe", q_rx.size(), 0);
        chk("R4 unknown opcode no tx request", txreq_seen, 0);

        // R5 deselect in the middle of the address
        clear_q();
        header(1'b0, 8'h20, 24'h0, 1'b0);
        send_byte(8'h12, dmy);
        sel_off(1'b0);
        chk("R5 partial address gives no command", q_op.size(), 0);

        // R7 program with two data bytes
        clear_q();
        header(1'b0, 8'h02, 24'h000010, 1'b1);
        send_byte(8'h3C, dmy);
        send_byte(8'hC3, dmy);
        sel_off(1'b0);
        expect_cmd("R7 program header", 8'h02, 19'h00010, 1'b1);
        chk("R7 rx byte count", q_rx.size(), 2);
        if (q_rx.size() == 2) begin
            chk("R7 rx byte 0", {24'd0, q_rx[0]}, 32'h3C);
            chk("R7 rx byte 1", {24'd0, q_rx[1]}, 32'hC3);
        end

        // R7 erase followed by a stray byte gives no strobe
        clear_q();
        header(1'b1, 8'h20, 24'h000000, 1'b1);
        send_byte(8'hA7, dmy);
        sel_off(1'b1);
        chk("R7 no rx strobe for erase", q_rx.size(), 0);

        // R8 R9 read, two bytes out
        clear_q();
        base = tx_cnt;
        header(1'b0, 8'h03, 24'h001234, 1'b1);
        send_byte(8'h00, r0);
        chk("R9 so_oe during read data", {31'd0, so_oe}, 1);
        send_byte(8'h00, r1);
        sel_off(1'b0);
        expect_cmd("R8 read header", 8'h03, 19'h01234, 1'b1);
        chk("R8 read byte 0", {24'd0, r0}, {24'd0, txb(base + 1)});
        chk("R8 read byte 1", {24'd0, r1}, {24'd0, txb(base + 2)});

        // R8 mode 3 identification read without address
        clear_q();
        base = tx_cnt;
        header(1'b1, 8'h9F, 24'h0, 1'b0);
        send_byte(8'h00, r0);
        sel_off(1'b1);
        chk("R8 ident byte mode3", {24'd0, r0}, {24'd0, txb(base + 1)});

        // R9 no drive during a non-transmit frame
        sel_on(1'b0);
        repeat (6) @(negedge clk);
        chk("R9 so_oe selected but idle", {31'd0, so_oe}, 0);
        sel_off(1'b0);

        // R10 hold inside the address, with SCK and SI activity during hold
        clear_q();
        header(1'b0, 8'h20, 24'h0, 1'b0);
        send_byte(8'h01, dmy);
        send_byte(8'h0A, dmy);
        for (int i = 7; i >= 4; i--) clk_bit(r0[0] ^ 8'h5C >> i, b);
        clear_q();
        @(negedge clk) sck = 1'b0;
        repeat (HALF) @(negedge clk);
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int k = 0; k < 2; k++) begin
            si = k[0];
            sck = 1'b1; repeat (HALF) @(negedge clk);
            sck = 1'b0; repeat (HALF) @(negedge clk);
        end
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        for (int i = 3; i >= 0; i--) clk_bit(1'(8'h5C >> i), b);
        sel_off(1'b0);
        chk("R10 hold in address command count", q_op.size(), 1);
        if (q_op.size() == 1) chk("R10 address after hold", {13'd0, q_addr[0]}, 32'h10A5C);
        else chk("R10 address after hold", 32'hFFFFFFFF, 32'h10A5C);

        // R10 hold during read data, and hold not starting while SCK is high
        clear_q();
        base = tx_cnt;
        header(1'b0, 8'h03, 24'h000000, 1'b1);
        for (int i = 7; i >= 4; i--) clk_bit(1'b0, r0[i]);
        @(negedge clk) sck = 1'b0;
        repeat (HALF) @(negedge clk);
        hold_n = 1'b0;
        repeat (4) @(negedge clk);
        chk("R10 so_oe low during hold", {31'd0, so_oe}, 0);
        sck = 1'b1; repeat (HALF) @(negedge clk);
        sck = 1'b0; repeat (HALF) @(negedge clk);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 so_oe back after hold", {31'd0, so_oe}, 1);
        for (int i = 3; i >= 0; i--) clk_bit(1'b0, r0[i]);
        hold_n = 1'b0;
        repeat (6) @(negedge clk);
        chk("R10 no hold while SCK high", {31'd0, so_oe}, 1);
        hold_n = 1'b1;
        repeat (4) @(negedge clk);
        send_byte(8'h00, r1);
        sel_off(1'b0);
        chk("R10 read byte 0 across hold", {24'd0, r0}, {24'd0, txb(base + 1)});
        chk("R10 read byte 1 after hold", {24'd0, r1}, {24'd0, txb(base + 2)});

        // R11 standby against busy and selection
        be_busy = 1'b1;
        repeat (4) @(negedge clk);
        chk("R11 busy clears standby", {31'd0, standby_ready}, 0);
        be_busy = 1'b0;
        repeat (4) @(negedge clk);
        chk("R11 standby after busy ends", {31'd0, standby_ready}, 1);
        sel_on(1'b0);
        repeat (2) @(negedge clk);
        chk("R11 no standby while selected", {31'd0, standby_ready}, 0);
        sel_off(1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule